// File: doc/BRIEF.md
# Frame-Sync Serial Port for a DSP Host

This block is the DSP-host transfer mode of a converter's serial interface. The host selects the mode by holding the frame-sync input low when it pulls the chip select low. The chip select may then stay low across any number of conversions. Each conversion is framed by a high-then-low pulse on the frame-sync input. A command byte follows on the data input and is captured on falling serial-clock edges.

From the command the block takes the channel number and issues a channel-select strobe, which marks the start of acquisition. It issues a sample strobe to the analog core and raises an outgoing frame-sync for one serial-clock period. It then shifts the converted result out, MSB first, on rising serial-clock edges. A narrow (8-clock command slot, 24-clock frame) and a wide (16-clock command slot, 32-clock frame) transfer width are supported.

All serial inputs are brought into the system clock domain through two-stage synchronizers. Edges are then detected on the synchronized levels. The serial clock must therefore be several times slower than the system clock.

Top module: `fsds_port`

## Requirements
- R1: `dsp_mode` goes high when `cs_n` falls while `fs_in` is low, stays low when `fs_in` is high at that fall, and returns low once `cs_n` rises.
- R2: In a frame, falling `sclk` edges are counted from the first falling edge after the `fs_in` falling edge. On the 3rd falling edge, `chan_stb` pulses for one system clock. At the same time `chan_sel` takes the first three `din` bits received, the first bit being the channel MSB (command bits 7..5).
- R3: Rising `sclk` edges are counted from the `fs_in` falling edge. `sample_stb` pulses exactly once per frame, on the 7th rising edge in narrow mode (`wide_xfer`=0) or on the 15th in wide mode (`wide_xfer`=1).
- R4: `fs_out` rises on the rising edge just after the sample edge (8th narrow, 16th wide) and falls on the next rising edge, so it is high for exactly one `sclk` period.
- R5: `dout` is 0 until the result starts. From the rising edge after `fs_out` rises (9th narrow, 17th wide), each rising edge puts out one bit of a 16-bit word: `conv_result` (taken at the `fs_out` edge) MSB first, then two 0 bits. After that word, further rising edges put out 0.
- R6: A new `fs_in` falling edge during a frame abandons that frame without a sample strobe. It restarts all counts, so the new frame behaves as in R2 to R5.
- R7: A rising `cs_n` during a frame abandons it. `dout` and `fs_out` go to 0, and no strobe follows for later `sclk` edges.
- R8: The command bits other than the channel bits (scan bits 4..3, reference bits 2..1, clock bit 0) have no effect. Any value still gives one sample strobe per frame and the same output timing.
- R9: After reset, `dsp_mode`, `chan_stb`, `sample_stb`, `fs_out` and `dout` are all 0.
- R10: While `dsp_mode` is 0, `sclk` and `fs_in` activity produces no strobe, and `fs_out` and `dout` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| fs_in | input | 1 | Frame-sync from the host; low at `cs_n` fall selects this mode |
| din | input | 1 | Serial command data |
| wide_xfer | input | 1 | 1 = 16-clock command slot, 0 = 8-clock slot |
| conv_result | input | 14 | Converted value from the analog core |
| dsp_mode | output | 1 | Frame-sync mode is active |
| chan_stb | output | 1 | One-cycle pulse: channel chosen, acquisition starts |
| chan_sel | output | 3 | Selected input channel |
| sample_stb | output | 1 | One-cycle pulse: take the sample |
| fs_out | output | 1 | Outgoing frame-sync, one `sclk` period wide |
| dout | output | 1 | Serial result data |

## Verification
A miscounted edge counter shows up as strobes and `fs_out` landing on the wrong serial-clock index. The error appears within the same frame, on the 3rd, 7th/15th or 8th/16th clock. A bad shift register shows up as a wrong bit at `dout` on the first affected rising edge, which the bench compares bit by bit over a full frame and the zero tail. A mode or abort flag that fails to clear shows up as strobes or non-zero `dout` after `cs_n` rises, or as a missing sample in the frame that follows an abandoned one.

// File: rtl/fsds_pkg.sv
// Shared constants for the frame-sync serial port.
// Assumes a 3-bit channel field at the head of the command byte.
package fsds_pkg;
    localparam int CMD_BITS  = 8;
    localparam int CHAN_BITS = 3;
    localparam int RES_BITS  = 14;
    localparam int WORD_BITS = 16;
    localparam int CNT_BITS  = 6;
endpackage

// File: rtl/fsds_sync.sv
// Two-stage synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent; reset values come from RST_VAL.
module fsds_sync #(
    parameter int          N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta;
        // Two flops per bit to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta      <= RST_VAL[i];
                sync_o[i] <= RST_VAL[i];
            end else begin
                meta      <= async_i[i];
                sync_o[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/fsds_seq.sv
// Mode latch, frame edge counters and strobe generation.
// Assumes synchronized inputs and a serial clock well below clk; wide_xfer static per frame.
module fsds_seq
    import fsds_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_s,
    input  logic                 cs_s,
    input  logic                 fs_s,
    input  logic                 din_s,
    input  logic                 wide_xfer,
    output logic                 dsp_mode,
    output logic                 chan_stb,
    output logic [CHAN_BITS-1:0] chan_sel,
    output logic                 sample_stb,
    output logic                 clear_o,
    output logic                 load_o,
    output logic                 tick_o
);
    localparam logic [CNT_BITS-1:0] CNT_MAX   = '1;
    localparam logic [CNT_BITS-1:0] CHAN_LAST = CNT_BITS'(CHAN_BITS - 1);
    localparam logic [CNT_BITS-1:0] SAMP_N    = CNT_BITS'(CMD_BITS - 2);
    localparam logic [CNT_BITS-1:0] SAMP_W    = CNT_BITS'(2*CMD_BITS - 2);

    logic                   sclk_q, cs_q, fs_q, in_frame;
    logic [CNT_BITS-1:0]    fcnt, rcnt;
    logic [CHAN_BITS-2:0]   chan_sh;
    logic                   sclk_r, sclk_f, cs_r, cs_f, fs_f, live, start, run;
    logic [CNT_BITS-1:0]    samp_prev;

    // Edge detection and frame qualifiers.
    always_comb begin
        sclk_r    = sclk_s & ~sclk_q;
        sclk_f    = ~sclk_s & sclk_q;
        cs_r      = cs_s & ~cs_q;
        cs_f      = ~cs_s & cs_q;
        fs_f      = ~fs_s & fs_q;
        live      = dsp_mode & ~cs_s;
        start     = live & fs_f;
        run       = live & in_frame & ~fs_f;
        samp_prev = wide_xfer ? SAMP_W : SAMP_N;
        clear_o   = start | cs_r | cs_f;
        tick_o    = run & sclk_r;
        load_o    = run & sclk_r & (rcnt == samp_prev + 1'b1);
    end

    // Previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            fs_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_s;
            fs_q   <= fs_s;
        end
    end

    // Mode latch and per-frame edge counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsp_mode <= 1'b0;
            in_frame <= 1'b0;
            fcnt     <= '0;
            rcnt     <= '0;
            chan_sh  <= '0;
        end else if (cs_r) begin
            dsp_mode <= 1'b0;
            in_frame <= 1'b0;
        end else if (cs_f) begin
            dsp_mode <= ~fs_s;
            in_frame <= 1'b0;
        end else if (start) begin
            in_frame <= 1'b1;
            fcnt     <= '0;
            rcnt     <= '0;
            chan_sh  <= '0;
        end else if (run) begin
            if (sclk_f && fcnt != CNT_MAX) begin
                fcnt <= fcnt + 1'b1;
                if (fcnt < CHAN_LAST) chan_sh <= {chan_sh, din_s};
            end
            if (sclk_r && rcnt != CNT_MAX) rcnt <= rcnt + 1'b1;
        end
    end

    // Registered channel and sample strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_stb   <= 1'b0;
            chan_sel   <= '0;
            sample_stb <= 1'b0;
        end else begin
            chan_stb   <= run & sclk_f & (fcnt == CHAN_LAST);
            sample_stb <= run & sclk_r & (rcnt == samp_prev);
            if (run && sclk_f && fcnt == CHAN_LAST) chan_sel <= {chan_sh, din_s};
        end
    end

    // R1: a rising chip select always leaves the mode next cycle.
    p_mode_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_r |=> !dsp_mode);
    // R2/R3: channel and sample strobes never coincide.
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chan_stb, sample_stb}));
    // R10: a sample strobe only appears in frame-sync mode.
    p_samp_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> dsp_mode);
endmodule

// File: rtl/fsds_shift.sv
// Outgoing frame-sync and result serializer.
// Assumes load and tick come from the same rising serial edge, load taking priority.
module fsds_shift
    import fsds_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                load,
    input  logic                tick,
    input  logic [RES_BITS-1:0] result,
    output logic                fs_out,
    output logic                dout
);
    localparam int PAD = WORD_BITS - RES_BITS;

    logic [WORD_BITS-1:0] sh;

    // Load the padded word with the sync edge, then shift one bit per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh     <= '0;
            dout   <= 1'b0;
            fs_out <= 1'b0;
        end else if (load) begin
            sh     <= {result, {PAD{1'b0}}};
            dout   <= 1'b0;
            fs_out <= 1'b1;
        end else if (tick) begin
            dout   <= sh[WORD_BITS-1];
            sh     <= {sh[WORD_BITS-2:0], 1'b0};
            fs_out <= 1'b0;
        end
    end

    // R7: an abort leaves both serial outputs low.
    p_clear_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!dout && !fs_out));
endmodule

// File: rtl/fsds_port.sv
// Frame-sync serial port top: synchronizers, sequencer, serializer.
// Assumes sclk, cs_n, fs_in, din asynchronous and at least 8x slower than clk.
module fsds_port
    import fsds_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk,
    input  logic                 cs_n,
    input  logic                 fs_in,
    input  logic                 din,
    input  logic                 wide_xfer,
    input  logic [RES_BITS-1:0]  conv_result,
    output logic                 dsp_mode,
    output logic                 chan_stb,
    output logic [CHAN_BITS-1:0] chan_sel,
    output logic                 sample_stb,
    output logic                 fs_out,
    output logic                 dout
);
    logic [3:0] sync_v;
    logic       clear_w, load_w, tick_w;

    fsds_sync #(.N(4), .RST_VAL(4'b0010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({din, fs_in, cs_n, sclk}),
        .sync_o  (sync_v)
    );

    fsds_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sync_v[0]),
        .cs_s       (sync_v[1]),
        .fs_s       (sync_v[2]),
        .din_s      (sync_v[3]),
        .wide_xfer  (wide_xfer),
        .dsp_mode   (dsp_mode),
        .chan_stb   (chan_stb),
        .chan_sel   (chan_sel),
        .sample_stb (sample_stb),
        .clear_o    (clear_w),
        .load_o     (load_w),
        .tick_o     (tick_w)
    );

    fsds_shift u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear_w),
        .load   (load_w),
        .tick   (tick_w),
        .result (conv_result),
        .fs_out (fs_out),
        .dout   (dout)
    );

    // R4: the outgoing sync only rises on the load edge.
    p_fs_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_out) |-> $past(load_w));
    // R10: no outgoing sync outside frame-sync mode.
    p_fs_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dsp_mode |-> !fs_out);
endmodule

// File: tb/tb_fsds_port.sv
module tb_fsds_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, fs_in = 1'b0, din = 1'b0, wide_xfer = 1'b0;
    logic [13:0] conv_result = '0;
    logic        dsp_mode, chan_stb, sample_stb, fs_out, dout;
    logic [2:0]  chan_sel;

    int checks = 0, fails = 0;
    int rcount = 0, fcount = 0;
    int samp_n = 0, samp_at = 0, chan_n = 0, chan_at = 0, chan_val = 0;
    logic fsv [0:40];
    logic dv  [0:40];
    bit   done = 0;

    always #2 clk = ~clk;

    fsds_port dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .fs_in(fs_in), .din(din),
        .wide_xfer(wide_xfer), .conv_result(conv_result), .dsp_mode(dsp_mode),
        .chan_stb(chan_stb), .chan_sel(chan_sel), .sample_stb(sample_stb),
        .fs_out(fs_out), .dout(dout)
    );

    // Strobe monitor: records where each strobe lands in serial-clock terms.
    always @(posedge clk) begin
        if (sample_stb) begin samp_n++; samp_at = rcount; end
        if (chan_stb) begin chan_n++; chan_at = fcount; chan_val = int'(chan_sel); end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        samp_n = 0; samp_at = 0; chan_n = 0; chan_at = 0; chan_val = 0;
        rcount = 0; fcount = 0;
        for (int i = 0; i <= 40; i++) begin fsv[i] = 1'b0; dv[i] = 1'b0; end
    endtask

    task automatic fs_pulse();
        fs_in = 1'b1;
        repeat (8) @(negedge clk);
        fs_in = 1'b0;
        clr_mon();
        repeat (8) @(negedge clk);
    endtask

    task automatic sclk_cyc(input logic b);
        sclk = 1'b1; rcount++; din = b;
        repeat (7) @(negedge clk);
        if (rcount <= 40) begin fsv[rcount] = fs_out; dv[rcount] = dout; end
        @(negedge clk);
        sclk = 1'b0; fcount++;
        repeat (8) @(negedge clk);
    endtask

    task automatic clocks(input logic [7:0] cmd, input int n);
        for (int k = 1; k <= n; k++) sclk_cyc(k <= 8 ? cmd[8-k] : 1'b0);
    endtask

    // Full frame with timing and data checks against R2..R5 (and R8 for scan bits).
    task automatic frame_chk(input bit w, input logic [7:0] cmd, input logic [13:0] res, input string tag);
        int y, n;
        longint act, exp;
        logic [15:0] word;
        wide_xfer = w; conv_result = res;
        fs_pulse();
        y = w ? 16 : 8;
        n = y + 20;
        clocks(cmd, n);
        chk(chan_n == 1 && chan_at == 3 && chan_val == int'(cmd[7:5]),
            {"R2 ", tag}, longint'(chan_n) * 256 + chan_at * 16 + chan_val,
            longint'(1) * 256 + 3 * 16 + int'(cmd[7:5]));
        chk(samp_n == 1 && samp_at == y - 1, (cmd[4:0] != 0) ? {"R3 R8 ", tag} : {"R3 ", tag},
            longint'(samp_n) * 256 + samp_at, longint'(256 + y - 1));
        act = 0; exp = 0;
        for (int k = 1; k <= n; k++) begin
            act = (act << 1) | longint'(fsv[k]);
            exp = (exp << 1) | longint'(k == y);
        end
        chk(act == exp, {"R4 ", tag}, act, exp);
        word = {res, 2'b00};
        act = 0; exp = 0;
        for (int k = 1; k <= n; k++) begin
            act = (act << 1) | longint'(dv[k]);
            exp = (exp << 1) | longint'((k > y && k <= y + 16) ? word[15 - (k - y - 1)] : 1'b0);
        end
        chk(act == exp, {"R5 ", tag}, act, exp);
    endtask

    // {wide, command, result}
    localparam logic [22:0] VEC [6] = '{
        {1'b0, 8'b101_00_110, 14'h2A5C},
        {1'b0, 8'b011_00_000, 14'h3FFF},
        {1'b1, 8'b110_00_011, 14'h0001},
        {1'b1, 8'b001_11_000, 14'h1234},
        {1'b0, 8'b111_01_001, 14'h2000},
        {1'b0, 8'b000_10_111, 14'h0ABC}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: outputs after reset
        chk(dsp_mode == 0 && fs_out == 0 && dout == 0, "R9 idle outputs",
            {dsp_mode, fs_out, dout}, 0);
        chk(chan_stb == 0 && sample_stb == 0, "R9 strobes", {chan_stb, sample_stb}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(dsp_mode == 0, "R9 mode after release", dsp_mode, 0);

        // R10: enter with fs_in high -> normal mode, frame-sync activity ignored
        fs_in = 1'b1; cs_n = 1'b0;
        repeat (8) @(negedge clk);
        chk(dsp_mode == 0, "R1 fs high at select", dsp_mode, 0);
        fs_in = 1'b0; clr_mon(); repeat (8) @(negedge clk);
        clocks(8'hA0, 28);
        chk(samp_n == 0 && chan_n == 0, "R10 no strobes", samp_n + chan_n, 0);
        begin
            longint a = 0;
            for (int k = 1; k <= 28; k++) a = (a << 1) | longint'(dv[k] | fsv[k]);
            chk(a == 0, "R10 outputs quiet", a, 0);
        end
        cs_n = 1'b1; repeat (8) @(negedge clk);

        // R1: enter frame-sync mode
        fs_in = 1'b0; cs_n = 1'b0;
        repeat (8) @(negedge clk);
        chk(dsp_mode == 1, "R1 mode entered", dsp_mode, 1);

        for (int i = 0; i < 6; i++)
            frame_chk(VEC[i][22], VEC[i][21:14], VEC[i][13:0], $sformatf("vector %0d", i));

        // R6: abandon a frame after 5 clocks, restart cleanly
        wide_xfer = 1'b0; fs_pulse(); clocks(8'hFF, 5);
        chk(samp_n == 0, "R6 aborted frame has no sample", samp_n, 0);
        frame_chk(1'b0, 8'b010_00_000, 14'h1555, "R6 restart");

        // R7: chip select rises mid-frame
        fs_pulse(); clocks(8'b100_00_000, 5);
        cs_n = 1'b1; repeat (8) @(negedge clk);
        chk(dsp_mode == 0, "R7 R1 mode cleared", dsp_mode, 0);
        samp_n = 0;
        clocks(8'h00, 20);
        chk(samp_n == 0 && dout == 0 && fs_out == 0, "R7 quiet after abort",
            {samp_n[3:0], dout, fs_out}, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule